// File: doc/BRIEF.md
# I2C Bus Condition Watcher with Slave Clock Stretch

This block sits beside a serial shift engine when it runs in I2C mode. It samples the open-drain SDA and SCL lines through synchronizers, recognizes START and STOP conditions, and turns them into a START interrupt flag, a STOP status flag and two single-cycle control pulses. One pulse clears the top bit of the shift register. The other forces the bit counter to one, so that an acknowledge bit still pending when a STOP arrives is completed.

In slave mode the block asks for SCL to be held low so that a remote master waits. It does so while the shift engine's completion flag is set, while the START flag is set, or while the bit counter reads zero. A release bit cancels the hold. In master mode it watches for lost arbitration: SCL rises while the block leaves SDA high, but the line reads low. It then records the loss and stops pulling SDA. Address matching and byte sequencing are left to software. The block only ever requests a pull-low on either line.

Top module: `i2c_line_watch`

## Requirements
- R1: After reset, start_flag, stop_flag, arb_lost, irq, scl_hold, sda_pull, msb_clr and cnt_load1 are all 0.
- R2: A falling SDA while SCL stays high is a START. Within six clock cycles of the line change, start_flag is 1 and exactly one msb_clr pulse has occurred, with no cnt_load1 pulse.
- R3: A rising SDA while SCL stays high is a STOP. Within six clock cycles, stop_flag is 1 and exactly one msb_clr pulse and exactly one cnt_load1 pulse have occurred.
- R4: SDA changes while SCL is low, and SCL edges with SDA steady, raise neither flag and produce no msb_clr or cnt_load1 pulse.
- R5: A START that arrives after data bits, with no STOP before it, is detected as a repeated START with the same effects as in R2.
- R6: scl_hold is 1 only when en=1, slave_mode=1, scl_rel=0 and at least one of done_flag, start_flag or cnt_zero is 1. scl_rel=1 and master mode (slave_mode=0) both release SCL.
- R7: irq equals (start_flag AND start_ie) OR (done_flag AND done_ie).
- R8: A one-cycle pulse on start_clr clears start_flag, and one on stop_clr clears stop_flag.
- R9: In master mode with sda_oe=1 and sda_bit=1, a rising SCL that finds SDA low sets arb_lost. While arb_lost is 1, sda_pull stays 0. A one-cycle arb_clr pulse clears arb_lost. A rising SCL with sda_bit=0 never sets it.
- R10: sda_pull is 1 exactly when en=1, sda_oe=1, sda_bit=0 and arb_lost=0. The block never drives either line high.
- R11: With en=0, START and STOP patterns change no flag and give no pulse, and scl_hold and sda_pull stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | I2C function enable |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| done_flag | input | 1 | Completion flag of the shift engine |
| cnt_zero | input | 1 | Bit counter reads zero |
| scl_rel | input | 1 | Release SCL from the slave hold |
| sda_oe | input | 1 | SDA output enable from the engine |
| sda_bit | input | 1 | Bit the engine presents on SDA (1 = release) |
| start_ie | input | 1 | START interrupt enable |
| done_ie | input | 1 | Completion interrupt enable |
| start_clr | input | 1 | Clear pulse for start_flag |
| stop_clr | input | 1 | Clear pulse for stop_flag |
| arb_clr | input | 1 | Clear pulse for arb_lost |
| start_flag | output | 1 | START seen |
| stop_flag | output | 1 | STOP seen |
| arb_lost | output | 1 | Arbitration lost |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to pull SCL low |
| sda_pull | output | 1 | Request to pull SDA low |
| msb_clr | output | 1 | Pulse: clear shift register MSB |
| cnt_load1 | output | 1 | Pulse: load bit counter with 1 |

## Verification
The bench toggles SDA while SCL is low and moves SCL with SDA steady. A detector that ignores the SCL level, or that looks only at the current level, would flag false conditions there. It sends a repeated START after data bits, which a design that expects a STOP first would miss. It counts pulses so that a STOP that fails to load the counter, or that fires twice, shows up. It goes through each cause of the slave hold and each way of releasing it. It provokes a lost arbitration and also a legal low drive at an SCL rise: a wrong polarity would set the flag in the legal case, and a missing output cut would keep pulling SDA after the loss.

// File: rtl/i2c_line_watch_pkg.sv
package i2c_line_watch_pkg;
   typedef struct packed {
      logic sda;
      logic scl;
   } line_t;

   localparam int LINE_W = $bits(line_t);
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("i2c_line_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
   import i2c_line_watch_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  line_t now,
   output logic  start_p,
   output logic  stop_p,
   output logic  scl_rise
);
   line_t prev;
   logic  scl_steady_hi;
   logic  start_evt;
   logic  stop_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '{sda: 1'b1, scl: 1'b1};
      else        prev <= now;
   end

   assign scl_steady_hi = prev.scl & now.scl;
   assign start_evt = en & scl_steady_hi &  prev.sda & ~now.sda;
   assign stop_evt  = en & scl_steady_hi & ~prev.sda &  now.sda;
   assign scl_rise  = ~prev.scl & now.scl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_p <= 1'b0;
         stop_p  <= 1'b0;
      end else begin
         start_p <= start_evt;
         stop_p  <= stop_evt;
      end
   end

   // R2 R3
   cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_p, stop_p}));
endmodule

// File: rtl/i2c_arb_watch.sv
module i2c_arb_watch #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic master,
   input  logic sda_oe,
   input  logic sda_bit,
   input  logic sda_lvl,
   input  logic scl_rise,
   input  logic arb_clr,
   output logic arb_lost
);
   generate
      if (ENABLE) begin : g_arb
         logic lose_evt;
         assign lose_evt = en & master & sda_oe & sda_bit & scl_rise & ~sda_lvl;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        arb_lost <= 1'b0;
            else if (lose_evt) arb_lost <= 1'b1;
            else if (arb_clr)  arb_lost <= 1'b0;
         end

         // R9
         arb_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(arb_lost) |-> $past(scl_rise) && $past(sda_bit));
      end else begin : g_noarb
         assign arb_lost = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_line_watch.sv
module i2c_line_watch
   import i2c_line_watch_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit ARB_DETECT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic slave_mode,
   input  logic sda_in,
   input  logic scl_in,
   input  logic done_flag,
   input  logic cnt_zero,
   input  logic scl_rel,
   input  logic sda_oe,
   input  logic sda_bit,
   input  logic start_ie,
   input  logic done_ie,
   input  logic start_clr,
   input  logic stop_clr,
   input  logic arb_clr,
   output logic start_flag,
   output logic stop_flag,
   output logic arb_lost,
   output logic irq,
   output logic scl_hold,
   output logic sda_pull,
   output logic msb_clr,
   output logic cnt_load1
);
   line_t raw;
   line_t lvl;
   logic  start_p;
   logic  stop_p;
   logic  scl_rise;
   logic  hold_cause;

   assign raw = '{sda: sda_in, scl: scl_in};

   i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_W), .RST_VAL('1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
   );

   i2c_cond_detect u_cond (
      .clk(clk), .rst_n(rst_n), .en(en), .now(lvl),
      .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise)
   );

   i2c_arb_watch #(.ENABLE(ARB_DETECT)) u_arb (
      .clk(clk), .rst_n(rst_n), .en(en), .master(~slave_mode),
      .sda_oe(sda_oe), .sda_bit(sda_bit), .sda_lvl(lvl.sda),
      .scl_rise(scl_rise), .arb_clr(arb_clr), .arb_lost(arb_lost)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         start_flag <= 1'b0;
      else if (start_p)   start_flag <= 1'b1;
      else if (start_clr) start_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stop_flag <= 1'b0;
      else if (stop_p)   stop_flag <= 1'b1;
      else if (stop_clr) stop_flag <= 1'b0;
   end

   assign msb_clr    = start_p | stop_p;
   assign cnt_load1  = stop_p;
   assign hold_cause = done_flag | start_flag | cnt_zero;
   assign scl_hold   = en & slave_mode & ~scl_rel & hold_cause;
   assign sda_pull   = en & sda_oe & ~sda_bit & ~arb_lost;
   assign irq        = (start_flag & start_ie) | (done_flag & done_ie);

   // R2
   start_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> start_flag);
   // R3
   stop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load1 |=> stop_flag);
   // R2
   start_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_flag) |-> $past(msb_clr));
   // R3
   stop_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_flag) |-> $past(cnt_load1));
endmodule

// File: tb/tb_i2c_line_watch.sv
`timescale 1ns/100ps
module tb_i2c_line_watch;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1, slave_mode = 1'b0, sda_in = 1'b1, scl_in = 1'b1;
   logic done_flag = 1'b0, cnt_zero = 1'b0, scl_rel = 1'b0, sda_oe = 1'b0, sda_bit = 1'b1;
   logic start_ie = 1'b0, done_ie = 1'b0, start_clr = 1'b0, stop_clr = 1'b0, arb_clr = 1'b0;
   logic start_flag, stop_flag, arb_lost, irq, scl_hold, sda_pull, msb_clr, cnt_load1;

   int checks = 0;
   int failures = 0;
   int n_msb = 0;
   int n_ld = 0;

   always #2.5 clk = ~clk;

   i2c_line_watch dut (
      .clk(clk), .rst_n(rst_n), .en(en), .slave_mode(slave_mode),
      .sda_in(sda_in), .scl_in(scl_in), .done_flag(done_flag), .cnt_zero(cnt_zero),
      .scl_rel(scl_rel), .sda_oe(sda_oe), .sda_bit(sda_bit), .start_ie(start_ie),
      .done_ie(done_ie), .start_clr(start_clr), .stop_clr(stop_clr), .arb_clr(arb_clr),
      .start_flag(start_flag), .stop_flag(stop_flag), .arb_lost(arb_lost), .irq(irq),
      .scl_hold(scl_hold), .sda_pull(sda_pull), .msb_clr(msb_clr), .cnt_load1(cnt_load1)
   );

   always @(negedge clk) begin
      if (msb_clr)   n_msb++;
      if (cnt_load1) n_ld++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic lines(input logic s, input logic c);
      @(negedge clk);
      sda_in = s;
      scl_in = c;
      repeat (6) @(negedge clk);
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic pulse_clr(input int which);
      @(negedge clk);
      if (which == 0) start_clr = 1'b1;
      if (which == 1) stop_clr  = 1'b1;
      if (which == 2) arb_clr   = 1'b1;
      @(negedge clk);
      start_clr = 1'b0; stop_clr = 1'b0; arb_clr = 1'b0;
      settle();
   endtask

   task automatic t_reset();
      #1;
      chk("R1 start_flag", start_flag, 0);
      chk("R1 stop_flag", stop_flag, 0);
      chk("R1 arb_lost", arb_lost, 0);
      chk("R1 irq", irq, 0);
      chk("R1 scl_hold", scl_hold, 0);
      chk("R1 sda_pull", sda_pull, 0);
      chk("R1 msb_clr", msb_clr, 0);
      chk("R1 cnt_load1", cnt_load1, 0);
   endtask

   task automatic t_start();
      lines(1, 1);
      n_msb = 0; n_ld = 0;
      lines(0, 1);
      chk("R2 start_flag", start_flag, 1);
      chk("R2 msb pulses", n_msb, 1);
      chk("R2 load pulses", n_ld, 0);
      chk("R2 stop_flag", stop_flag, 0);
      pulse_clr(0);
      chk("R8 start cleared", start_flag, 0);
   endtask

   task automatic t_quiet();
      lines(0, 0);
      n_msb = 0; n_ld = 0;
      lines(1, 0);
      lines(0, 0);
      lines(1, 0);
      lines(1, 1);
      lines(1, 0);
      chk("R4 start_flag", start_flag, 0);
      chk("R4 stop_flag", stop_flag, 0);
      chk("R4 msb pulses", n_msb, 0);
      chk("R4 load pulses", n_ld, 0);
   endtask

   task automatic t_repeat();
      lines(1, 1);
      n_msb = 0; n_ld = 0;
      lines(0, 1);
      chk("R5 start_flag", start_flag, 1);
      chk("R5 msb pulses", n_msb, 1);
      chk("R5 load pulses", n_ld, 0);
      lines(0, 0);
   endtask

   task automatic t_stop();
      n_msb = 0; n_ld = 0;
      lines(0, 1);
      lines(1, 1);
      chk("R3 stop_flag", stop_flag, 1);
      chk("R3 msb pulses", n_msb, 1);
      chk("R3 load pulses", n_ld, 1);
      pulse_clr(0);
      pulse_clr(1);
      chk("R8 stop cleared", stop_flag, 0);
      chk("R8 start cleared", start_flag, 0);
   endtask

   task automatic t_hold();
      slave_mode = 1'b1; done_flag = 1'b0; cnt_zero = 1'b0; scl_rel = 1'b0;
      settle();
      chk("R6 no cause", scl_hold, 0);
      done_flag = 1'b1; settle();
      chk("R6 done hold", scl_hold, 1);
      scl_rel = 1'b1; settle();
      chk("R6 release", scl_hold, 0);
      scl_rel = 1'b0; done_flag = 1'b0; cnt_zero = 1'b1; settle();
      chk("R6 cnt zero hold", scl_hold, 1);
      cnt_zero = 1'b0; settle();
      chk("R6 cnt nonzero", scl_hold, 0);
      lines(0, 1);
      chk("R6 start hold", scl_hold, 1);
      pulse_clr(0);
      chk("R6 start cleared", scl_hold, 0);
      slave_mode = 1'b0; done_flag = 1'b1; settle();
      chk("R6 master no hold", scl_hold, 0);
      done_flag = 1'b0;
      lines(0, 0);
      lines(1, 0);
      lines(1, 1);
   endtask

   task automatic t_irq();
      done_flag = 1'b1; done_ie = 1'b0; settle();
      chk("R7 done masked", irq, 0);
      done_ie = 1'b1; settle();
      chk("R7 done enabled", irq, 1);
      done_flag = 1'b0; settle();
      chk("R7 done gone", irq, 0);
      lines(0, 1);
      chk("R7 start masked", irq, 0);
      start_ie = 1'b1; settle();
      chk("R7 start enabled", irq, 1);
      pulse_clr(0);
      chk("R7 start cleared", irq, 0);
      start_ie = 1'b0; done_ie = 1'b0;
      lines(0, 0);
   endtask

   task automatic t_drive();
      slave_mode = 1'b0; sda_oe = 1'b0; sda_bit = 1'b0; settle();
      chk("R10 oe off", sda_pull, 0);
      sda_oe = 1'b1; sda_bit = 1'b1; settle();
      chk("R10 release bit", sda_pull, 0);
      sda_bit = 1'b0; settle();
      chk("R10 low bit", sda_pull, 1);
   endtask

   task automatic t_arb();
      sda_oe = 1'b1; sda_bit = 1'b0;
      lines(0, 0);
      lines(0, 1);
      chk("R9 own low no loss", arb_lost, 0);
      lines(0, 0);
      sda_bit = 1'b1;
      lines(0, 1);
      chk("R9 loss set", arb_lost, 1);
      sda_bit = 1'b0; settle();
      chk("R9 output cut", sda_pull, 0);
      lines(0, 0);
      pulse_clr(2);
      chk("R9 loss cleared", arb_lost, 0);
      chk("R9 drive back", sda_pull, 1);
      sda_oe = 1'b0; sda_bit = 1'b1;
      lines(1, 0);
      lines(1, 1);
   endtask

   task automatic t_disable();
      en = 1'b0;
      n_msb = 0; n_ld = 0;
      lines(0, 1);
      lines(1, 1);
      chk("R11 start_flag", start_flag, 0);
      chk("R11 stop_flag", stop_flag, 0);
      chk("R11 pulses", n_msb + n_ld, 0);
      slave_mode = 1'b1; done_flag = 1'b1; sda_oe = 1'b1; sda_bit = 1'b0; settle();
      chk("R11 scl_hold", scl_hold, 0);
      chk("R11 sda_pull", sda_pull, 0);
      en = 1'b1; slave_mode = 1'b0; done_flag = 1'b0; sda_oe = 1'b0; sda_bit = 1'b1;
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_start();
      t_quiet();
      t_repeat();
      t_stop();
      t_hold();
      t_irq();
      t_drive();
      t_arb();
      t_disable();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule